// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It generates its own shift clock and moves one byte per transfer. An output data line carries the transmit bits. A separate input line is sampled to build the receive byte. The host writes a byte to start a transfer. It then polls a sticky completion flag and reads back the byte that was captured.

Two speed modes are offered: a slow mode with 12 system clocks per bit and a fast mode with 4 system clocks per bit. Within each bit frame, the output update and the input sample sit at fixed cycle offsets from the shift-clock rising edge. An external shift-register device can therefore rely on exact timing. The mode is latched when the byte is written, so a change on the mode pin during a transfer has no effect.

Top module: `ssp_port`

## Requirements
- R1: After reset, sclk_o and sdo_o are 1, while busy_o, done_o, overrun_o and rx_data_o are 0.
- R2: A write (wr_en_i=1) while busy_o=0 starts a transfer. On the next cycle busy_o=1, done_o=0 and sdo_o carries bit 0 of the written byte.
- R3: Bits leave least significant first. Bit b stays on sdo_o for all cycles of frame b. sdo_o changes only in the first cycle of a frame.
- R4: Slow mode (fast_i=0 at write) uses frames of 12 cycles. Numbering the frame cycles 0..11, sclk_o is low in cycles 1..9 and high in cycles 10, 11 and 0. The rising edge therefore falls 10 cycles after the data update, and the high pulse lasts 3 cycles.
- R5: Fast mode (fast_i=1 at write) uses frames of 4 cycles. sclk_o is low in cycles 1..2 and high in cycles 3 and 0. The data update therefore falls 1 cycle after the rising edge, and the high pulse lasts 2 cycles.
- R6: In both modes, sdi_i is captured on the clock edge that lies 2 system clocks before the shift-clock rising edge. This is the edge that ends cycle 7 (slow) or cycle 0 (fast) of the frame. sdi_i has no effect in any other cycle.
- R7: A transfer lasts 8 frames. In the next cycle busy_o=0, done_o=1 and rx_data_o holds the 8 samples (first sample in bit 0). Also in that cycle, sclk_o idles high and sdo_o holds bit 7.
- R8: done_o stays 1 until clr_done_i=1 or until a new write is accepted. rx_data_o changes only when a transfer completes.
- R9: A write while busy_o=1 is ignored and leaves the ongoing bit stream unchanged. It sets overrun_o, which stays 1 until clr_done_i=1.
- R10: The speed mode is taken from fast_i at the accepted write. Changing fast_i during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the transmit byte |
| wr_data_i | input | 8 | Byte to transmit |
| fast_i | input | 1 | Speed mode for the next transfer (1 = 4 clocks/bit) |
| clr_done_i | input | 1 | Clears done_o and overrun_o |
| sdi_i | input | 1 | Serial input data |
| sclk_o | output | 1 | Shift clock, idles high |
| sdo_o | output | 1 | Serial output data |
| rx_data_o | output | 8 | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| overrun_o | output | 1 | Sticky write-while-busy flag |

## Verification
The bench builds the port with its default parameters: 8-bit data, frames of 12 and 4 cycles, high pulses of 3 and 2 cycles, and a sample lead of 2. Every frame cycle of both speed modes is therefore checked against the expected placement. In each frame, sdi_i carries the intended bit only in the one sampling cycle and the inverted bit in every other cycle. An off-by-one sample point therefore corrupts the received byte. The bench also writes during a transfer and toggles the mode pin during a transfer to show that neither disturbs the stream.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {SPD_SLOW = 1'b0, SPD_FAST = 1'b1} spd_e;
endpackage

// File: rtl/ssp_timer.sv
module ssp_timer #(
  parameter int SLOW_DIV = 12,
  parameter int SLOW_HI  = 3,
  parameter int FAST_DIV = 4,
  parameter int FAST_HI  = 2,
  parameter int LEAD     = 2,
  localparam int PH_W    = $clog2(SLOW_DIV)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         run_i,
  input  ssp_pkg::spd_e spd_i,
  output logic         frame_end_o,
  output logic         sample_o,
  output logic         sclk_o
);
  import ssp_pkg::*;

  localparam int SLOW_RISE = SLOW_DIV - SLOW_HI + 1;
  localparam int FAST_RISE = FAST_DIV - FAST_HI + 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph, rise_ph, samp_ph;

  always_comb begin
    if (spd_i == SPD_FAST) begin
      last_ph = PH_W'(FAST_DIV - 1);
      rise_ph = PH_W'(FAST_RISE);
      samp_ph = PH_W'(FAST_RISE - 1 - LEAD);
    end else begin
      last_ph = PH_W'(SLOW_DIV - 1);
      rise_ph = PH_W'(SLOW_RISE);
      samp_ph = PH_W'(SLOW_RISE - 1 - LEAD);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ph_q <= '0;
    else if (start_i)                  ph_q <= '0;
    else if (run_i && ph_q == last_ph) ph_q <= '0;
    else if (run_i)                    ph_q <= ph_q + 1'b1;
  end

  assign frame_end_o = run_i && (ph_q == last_ph);
  assign sample_o    = run_i && (ph_q == samp_ph);
  // low between the data update cycle and the rising edge
  assign sclk_o      = !(run_i && ph_q != '0 && ph_q < rise_ph);

  p_phase_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ph_q <= last_ph);
  p_sample_in_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && spd_i == SPD_SLOW) |-> !sclk_o);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              capture_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [DATA_W-1:0] tx_q, rx_sh_q, rx_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      sdo_q <= 1'b1;
    end else if (load_i) begin
      sdo_q <= load_data_i[0];
      tx_q  <= load_data_i >> 1;
    end else if (shift_i) begin
      sdo_q <= tx_q[0];
      tx_q  <= tx_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_sh_q <= '0;
    else if (sample_i) rx_sh_q <= {sdi_i, rx_sh_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_q <= '0;
    else if (capture_i) rx_q <= rx_sh_q;
  end

  assign sdo_o     = sdo_q;
  assign rx_data_o = rx_q;

  p_rx_only_on_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rx_q));
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int SLOW_HI  = 3,
  parameter int FAST_DIV = 4,
  parameter int FAST_HI  = 2,
  parameter int LEAD     = 2,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fast_i,
  input  logic              clr_done_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrun_o
);
  import ssp_pkg::*;

  logic             busy_q, done_q, ovr_q;
  logic [CNT_W-1:0] bit_q;
  spd_e             spd_q;
  logic             start, frame_end, sample, last_bit, complete;

  assign start    = wr_en_i && !busy_q;
  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));
  assign complete = frame_end && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      spd_q  <= SPD_SLOW;
    end else if (start) begin
      busy_q <= 1'b1;
      bit_q  <= '0;
      spd_q  <= fast_i ? SPD_FAST : SPD_SLOW;
    end else if (complete) begin
      busy_q <= 1'b0;
    end else if (frame_end) begin
      bit_q  <= bit_q + 1'b1;
    end
  end

  // completion outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   done_q <= 1'b0;
    else if (complete)             done_q <= 1'b1;
    else if (clr_done_i || start)  done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovr_q <= 1'b0;
    else if (wr_en_i && busy_q)    ovr_q <= 1'b1;
    else if (clr_done_i)           ovr_q <= 1'b0;
  end

  ssp_timer #(
    .SLOW_DIV(SLOW_DIV), .SLOW_HI(SLOW_HI),
    .FAST_DIV(FAST_DIV), .FAST_HI(FAST_HI), .LEAD(LEAD)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .run_i       (busy_q),
    .spd_i       (spd_q),
    .frame_end_o (frame_end),
    .sample_o    (sample),
    .sclk_o      (sclk_o)
  );

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_data_i (wr_data_i),
    .shift_i     (frame_end && !last_bit),
    .sample_i    (sample),
    .sdi_i       (sdi_i),
    .capture_i   (complete),
    .sdo_o       (sdo_o),
    .rx_data_o   (rx_data_o)
  );

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;

  p_sclk_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);
  p_done_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_sdo_stable_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sclk_o) |-> $stable(sdo_o));
  p_overrun_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i) |=> overrun_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i) |=> (busy_o && !done_o));
  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rx_data_o));
endmodule

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       fast_i = 1'b0;
  logic       clr_done_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       sclk_o, sdo_o, busy_o, done_o, overrun_o;
  logic [7:0] rx_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  ssp_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .fast_i(fast_i), .clr_done_i(clr_done_i), .sdi_i(sdi_i), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .rx_data_o(rx_data_o), .busy_o(busy_o), .done_o(done_o),
    .overrun_o(overrun_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full transfer, every cycle compared against the frame rules
  task automatic run_xfer(input bit fast, input logic [7:0] tx, input logic [7:0] rx,
                          input int flip_at, input int ovr_at);
    int div   = fast ? 4 : 12;
    int rise  = fast ? 3 : 10;
    int samp  = rise - 3;
    int e_sclk = 0, e_sdo = 0;
    bit got_busy;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = tx; fast_i = fast;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    // R2
    check(busy_o == 1'b1 && done_o == 1'b0 && sdo_o == tx[0], "R2", {busy_o, done_o, sdo_o}, {2'b10, tx[0]});
    got_busy = 1'b1;
    for (int c = 0; c < 8 * div; c++) begin
      int b = c / div;
      int p = c % div;
      bit exp_sclk = !(p != 0 && p < rise);
      if (!busy_o) got_busy = 1'b0;
      if (sclk_o != exp_sclk) e_sclk++;
      if (sdo_o != tx[b]) e_sdo++;
      sdi_i = (p == samp) ? rx[b] : ~rx[b];
      wr_en_i = (c == ovr_at);
      wr_data_i = (c == ovr_at) ? ~tx : tx;
      if (c == flip_at) fast_i = ~fast;
      @(negedge clk_i);
    end
    wr_en_i = 1'b0;
    check(got_busy, "R7 busy held", 0, 1);
    check(e_sdo == 0, "R3 sdo per frame", e_sdo, 0);
    check(e_sclk == 0, fast ? "R5 fast sclk" : "R4 slow sclk", e_sclk, 0);
    check(rx_data_o == rx, "R6 sample point", rx_data_o, rx);
    check(busy_o == 1'b0 && done_o == 1'b1 && sclk_o == 1'b1 && sdo_o == tx[7],
          "R7 completion", {busy_o, done_o, sclk_o, sdo_o}, {3'b011, tx[7]});
    if (flip_at >= 0) check(e_sclk == 0 && rx_data_o == rx, "R10 mode frozen", e_sclk, 0);
    if (ovr_at >= 0) check(overrun_o == 1'b1 && e_sdo == 0, "R9 overrun", overrun_o, 1);
  endtask

  task automatic t_reset;
    check(sclk_o && sdo_o && !busy_o && !done_o && !overrun_o && rx_data_o == 8'h00,
          "R1 reset", {sclk_o, sdo_o, busy_o, done_o, overrun_o}, 5'b11000);
  endtask

  task automatic t_slow;
    run_xfer(1'b0, 8'hA5, 8'h3C, -1, -1);
    run_xfer(1'b0, 8'h01, 8'h80, -1, -1);
  endtask

  task automatic t_fast;
    run_xfer(1'b1, 8'h5A, 8'hC3, -1, -1);
    run_xfer(1'b1, 8'hFE, 8'h7F, -1, -1);
  endtask

  task automatic t_sticky;
    logic [7:0] keep = rx_data_o;
    sdi_i = 1'b1;
    repeat (20) @(negedge clk_i);
    check(done_o == 1'b1 && rx_data_o == keep, "R8 done sticky", done_o, 1);
    clr_done_i = 1'b1;
    @(negedge clk_i);
    clr_done_i = 1'b0;
    check(done_o == 1'b0 && rx_data_o == keep && !busy_o, "R8 done cleared", done_o, 0);
  endtask

  task automatic t_overrun;
    run_xfer(1'b0, 8'h96, 8'h69, -1, 17);
    repeat (5) @(negedge clk_i);
    check(overrun_o == 1'b1, "R9 overrun sticky", overrun_o, 1);
    clr_done_i = 1'b1;
    @(negedge clk_i);
    clr_done_i = 1'b0;
    check(overrun_o == 1'b0 && done_o == 1'b0, "R9 overrun cleared", overrun_o, 0);
  endtask

  task automatic t_mode_freeze;
    run_xfer(1'b1, 8'h33, 8'hE1, 2, -1);
    run_xfer(1'b0, 8'hCC, 8'h1E, 5, 30);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_slow();
        t_sticky();
        t_fast();
        t_overrun();
        t_mode_freeze();
      end
      begin
        repeat (100000) @(posedge clk_i);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) cyc <= cyc + 1;
endmodule